// File: doc/BRIEF.md
# Circular Register Stack Spill Controller

This block holds the local registers of a processor as a ring of on-chip words and keeps the stack frames of nested subroutines inside it. Software addresses a local register by a small index taken relative to the current frame base. A call opens a new frame at the end of the current one, and the new frame may share its first words with the caller's last words so that arguments need no copying. A return brings back the caller's frame base and size from a small internal descriptor stack.

The ring has a fixed capacity. When a call would leave the frames reaching further than that capacity from the oldest resident word, the controller writes the oldest words out to memory one at a time. When a return exposes a frame whose bottom words were written out earlier, it reads them back in last-in-first-out order. Each transfer moves one word per memory acknowledge. While a transfer is pending the block reports busy, and register writes, calls and returns are ignored. Words are tracked by absolute stack position: position p lives in ring slot p mod 64 and, once spilled, at memory word address p. The memory stack pointer, which equals the absolute position of the oldest resident word, is compared against a bound input to flag a stack overflow.

Top module: `regstack_spill`

## Requirements
- R1: After a synchronous active-low reset the frame base is 0, the frame size is 16, the memory stack pointer is 0, and busy, mem_req and stk_ovf are low.
- R2: Local index n reads and writes ring slot (frame_base + n) mod 64, so a callee created with overlap k sees at its index i (i < k) the word the caller holds at index caller_size - k + i, and writes made there are seen by the caller after the return.
- R3: An accepted call sets the new frame base to old base + old size - overlap and the new size to call_size; an overlap larger than the current size is treated as the current size, a call_size of 0 as 1 and a call_size above 16 as 16.
- R4: When frame_base + frame_size - mem_sp exceeds 64, the block raises mem_req with mem_we high, mem_addr equal to mem_sp and mem_wdata equal to the word at that position; each acknowledge advances mem_sp by one until the excess is gone.
- R5: An accepted return restores the previous frame base and size; if the restored base is below mem_sp, the block raises mem_req with mem_we low and mem_addr equal to mem_sp - 1, stores mem_rdata into that position on acknowledge and decrements mem_sp, until mem_sp equals the base.
- R6: busy is high exactly while a spill or fill is pending; register writes, calls and returns presented while busy is high have no effect.
- R7: stk_ovf is high whenever mem_sp is greater than stack_bound.
- R8: The descriptor stack holds 8 frames; a call when 8 frames are open and a return when none are open are ignored.
- R9: When call_req and ret_req are both high in the same cycle, the call is acted on and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_idx | input | 4 | Local register index to read |
| rd_data | output | 32 | Contents of the local register at rd_idx |
| wr_en | input | 1 | Write the local register at wr_idx |
| wr_idx | input | 4 | Local register index to write |
| wr_data | input | 32 | Data to write |
| call_req | input | 1 | Open a new frame |
| call_ovl | input | 5 | Number of caller words shared with the new frame |
| call_size | input | 5 | Size in words of the new frame (1 to 16) |
| ret_req | input | 1 | Close the current frame |
| stack_bound | input | 16 | Highest allowed memory stack pointer |
| busy | output | 1 | Spill or fill pending |
| frame_base | output | 16 | Absolute stack position of local index 0 |
| frame_size | output | 5 | Size of the current frame |
| mem_sp | output | 16 | Memory stack pointer (oldest resident position) |
| stk_ovf | output | 1 | Memory stack pointer above stack_bound |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for a spill write, 0 for a fill read |
| mem_addr | output | 16 | Word address of the transfer |
| mem_wdata | output | 32 | Word being spilled |
| mem_rdata | input | 32 | Word being filled |
| mem_ack | input | 1 | Transfer of one word done |

## Verification
The hardest situation to reach from the ports is a refill that lands on ring slots still holding a later frame's words, since it needs four full frames open so that the fourth pushes the first out to memory, then a write into the slots the first frame used, then returns all the way down. The bench builds exactly that chain of 16-word frames, marks the reused slot with a fresh value, and after the last return reads the first frame back to prove the refill replaced it. It also holds the memory acknowledge off during the spill and the fill, so the busy window is long enough to present a write and a call inside it and to observe the pending request's address and data.

// File: rtl/rstk_pkg.sv
// Package: shared types of the register stack spill controller.
// Assumes nothing beyond IEEE 1800-2017.
package rstk_pkg;

    // Transfer activity of the spill/fill engine.
    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_SPILL = 2'd1,
        XF_FILL  = 2'd2
    } xfer_e;

endpackage

// File: rtl/rstk_regfile.sv
// Module: ring storage of the local registers.
// One write port, two combinational read ports (register read and spill
// data). Storage is not reset; the controller never reads a slot it has
// not written or filled.
module rstk_regfile #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WORD_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr_a,
    output logic [WORD_W-1:0]        rdata_a,
    input  logic [$clog2(DEPTH)-1:0] raddr_b,
    output logic [WORD_W-1:0]        rdata_b
);
    logic [WORD_W-1:0] ring_q [DEPTH];

    // Write one slot per cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            ring_q[waddr] <= wdata;
        end
    end

    // Read both ports combinationally.
    always_comb begin
        rdata_a = ring_q[raddr_a];
        rdata_b = ring_q[raddr_b];
    end
endmodule

// File: rtl/rstk_frame_stack.sv
// Module: LIFO of frame descriptors (base position and size of the caller).
// Assumes the caller never pushes when full nor pops when empty.
module rstk_frame_stack #(
    parameter int ENTRIES = 8,
    parameter int PTR_W   = 16,
    parameter int SIZE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PTR_W-1:0]  push_base,
    input  logic [SIZE_W-1:0] push_size,
    output logic [PTR_W-1:0]  top_base,
    output logic [SIZE_W-1:0] top_size,
    output logic              full,
    output logic              empty
);
    localparam int CNT_W = $clog2(ENTRIES + 1);
    localparam int IX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [PTR_W-1:0]  base_q [ENTRIES];
    logic [SIZE_W-1:0] size_q [ENTRIES];
    logic [CNT_W-1:0]  cnt_q;
    logic [IX_W-1:0]   top_ix;

    always_comb begin
        full   = (cnt_q == CNT_W'(ENTRIES));
        empty  = (cnt_q == '0);
        top_ix = IX_W'(cnt_q - CNT_W'(1));
        top_base = base_q[top_ix];
        top_size = size_q[top_ix];
    end

    // Track the number of open descriptors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Store a descriptor in the next free entry.
    always_ff @(posedge clk) begin
        if (push) begin
            base_q[IX_W'(cnt_q)] <= push_base;
            size_q[IX_W'(cnt_q)] <= push_size;
        end
    end

    assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rstk_xfer_ctrl.sv
// Module: spill/fill engine. Owns the memory stack pointer (absolute
// position of the oldest resident word) and decides whether words must go
// out to memory or come back. Assumes frame_base never runs below the
// pointer while a spill is needed, so the two cases never coexist.
module rstk_xfer_ctrl
    import rstk_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] frame_base,
    input  logic [PTR_W-1:0] frame_top,
    input  logic             mem_ack,
    output logic [PTR_W-1:0] sp,
    output xfer_e            mode
);
    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] span;

    // Select the pending transfer from the window extent.
    always_comb begin
        span = frame_top - sp_q;
        if (span > PTR_W'(DEPTH)) begin
            mode = XF_SPILL;
        end else if (frame_base < sp_q) begin
            mode = XF_FILL;
        end else begin
            mode = XF_IDLE;
        end
        sp = sp_q;
    end

    // Move the pointer by one word per acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (mem_ack) begin
            if (mode == XF_SPILL) begin
                sp_q <= sp_q + PTR_W'(1);
            end else if (mode == XF_FILL) begin
                sp_q <= sp_q - PTR_W'(1);
            end
        end
    end

    assert_spill_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XF_SPILL && mem_ack) |=> sp_q == $past(sp_q) + PTR_W'(1));
    assert_fill_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XF_FILL && mem_ack) |=> sp_q == $past(sp_q) - PTR_W'(1));
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XF_IDLE) |=> $stable(sp_q));
endmodule

// File: rtl/regstack_spill.sv
// Module: circular local register stack with automatic spill and fill.
// Local index n maps to ring slot (frame_base + n) mod DEPTH. Calls open a
// possibly overlapping frame, returns reopen the caller's frame from the
// descriptor stack. Assumes a single requester and a memory that holds
// mem_ack high for one cycle per word.
module regstack_spill
    import rstk_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int WORD_W    = 32,
    parameter int MAX_FRAME = 16,
    parameter int FRAMES    = 8,
    parameter int PTR_W     = 16,
    localparam int LOC_W    = $clog2(MAX_FRAME),
    localparam int SIZE_W   = $clog2(MAX_FRAME) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOC_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [LOC_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              call_req,
    input  logic [SIZE_W-1:0] call_ovl,
    input  logic [SIZE_W-1:0] call_size,
    input  logic              ret_req,
    input  logic [PTR_W-1:0]  stack_bound,
    output logic              busy,
    output logic [PTR_W-1:0]  frame_base,
    output logic [SIZE_W-1:0] frame_size,
    output logic [PTR_W-1:0]  mem_sp,
    output logic              stk_ovf,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [PTR_W-1:0]  fp_q;
    logic [SIZE_W-1:0] fsz_q;
    logic [PTR_W-1:0]  frame_top;
    logic [PTR_W-1:0]  new_base;
    logic [SIZE_W-1:0] size_eff;
    logic [SIZE_W-1:0] ovl_eff;
    logic              call_go;
    logic              ret_go;
    logic              fs_full;
    logic              fs_empty;
    logic [PTR_W-1:0]  fs_base;
    logic [SIZE_W-1:0] fs_size;
    logic [PTR_W-1:0]  sp;
    xfer_e             mode;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_waddr;
    logic [WORD_W-1:0] rf_wdata;
    logic [IDX_W-1:0]  rd_slot;
    logic [WORD_W-1:0] spill_word;

    // Decode requests and clamp the call operands.
    always_comb begin
        frame_top = fp_q + PTR_W'(fsz_q);
        busy      = (mode != XF_IDLE);
        if (call_size == '0) begin
            size_eff = SIZE_W'(1);
        end else if (call_size > SIZE_W'(MAX_FRAME)) begin
            size_eff = SIZE_W'(MAX_FRAME);
        end else begin
            size_eff = call_size;
        end
        ovl_eff  = (call_ovl > fsz_q) ? fsz_q : call_ovl;
        new_base = frame_top - PTR_W'(ovl_eff);
        call_go  = call_req && !busy && !fs_full;
        ret_go   = ret_req && !call_req && !busy && !fs_empty;
    end

    // Hold the current frame base and size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_q  <= '0;
            fsz_q <= SIZE_W'(MAX_FRAME);
        end else if (call_go) begin
            fp_q  <= new_base;
            fsz_q <= size_eff;
        end else if (ret_go) begin
            fp_q  <= fs_base;
            fsz_q <= fs_size;
        end
    end

    // Steer the single ring write port between fill data and register writes.
    always_comb begin
        rd_slot = fp_q[IDX_W-1:0] + IDX_W'(rd_idx);
        if (mode == XF_FILL) begin
            rf_we    = mem_ack;
            rf_waddr = sp[IDX_W-1:0] - IDX_W'(1);
            rf_wdata = mem_rdata;
        end else begin
            rf_we    = wr_en && !busy;
            rf_waddr = fp_q[IDX_W-1:0] + IDX_W'(wr_idx);
            rf_wdata = wr_data;
        end
    end

    // Drive the memory port and status outputs.
    always_comb begin
        mem_req    = busy;
        mem_we     = (mode == XF_SPILL);
        mem_addr   = (mode == XF_FILL) ? sp - PTR_W'(1) : sp;
        mem_wdata  = spill_word;
        mem_sp     = sp;
        stk_ovf    = (sp > stack_bound);
        frame_base = fp_q;
        frame_size = fsz_q;
    end

    rstk_regfile #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) u_ring (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (rd_slot),
        .rdata_a (rd_data),
        .raddr_b (sp[IDX_W-1:0]),
        .rdata_b (spill_word)
    );

    rstk_frame_stack #(
        .ENTRIES (FRAMES),
        .PTR_W   (PTR_W),
        .SIZE_W  (SIZE_W)
    ) u_frames (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (call_go),
        .pop       (ret_go),
        .push_base (fp_q),
        .push_size (fsz_q),
        .top_base  (fs_base),
        .top_size  (fs_size),
        .full      (fs_full),
        .empty     (fs_empty)
    );

    rstk_xfer_ctrl #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_base (fp_q),
        .frame_top  (frame_top),
        .mem_ack    (mem_ack),
        .sp         (sp),
        .mode       (mode)
    );

    assert_frozen_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(fp_q) && $stable(fsz_q)));
    assert_size_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsz_q >= SIZE_W'(1)) && (fsz_q <= SIZE_W'(MAX_FRAME)));
    assert_window_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (PTR_W'(fp_q + PTR_W'(fsz_q) - sp) <= PTR_W'(DEPTH)) && (fp_q >= sp));
endmodule

// File: tb/regstack_spill_tb.sv
`timescale 1ns/1ps
module regstack_spill_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_idx;
    logic [31:0] rd_data;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;
    logic        call_req;
    logic [4:0]  call_ovl;
    logic [4:0]  call_size;
    logic        ret_req;
    logic [15:0] stack_bound;
    logic        busy;
    logic [15:0] frame_base;
    logic [4:0]  frame_size;
    logic [15:0] mem_sp;
    logic        stk_ovf;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;

    logic [31:0] mem_model [256];
    logic        ack_hold;
    int          n_chk  = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    regstack_spill u_dut (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .call_req(call_req), .call_ovl(call_ovl), .call_size(call_size),
        .ret_req(ret_req), .stack_bound(stack_bound), .busy(busy),
        .frame_base(frame_base), .frame_size(frame_size), .mem_sp(mem_sp),
        .stk_ovf(stk_ovf), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    // Memory responder: one acknowledge pulse per word, unless held off.
    always @(negedge clk) begin
        if (mem_req && !mem_ack && !ack_hold) begin
            mem_ack <= 1'b1;
            if (mem_we) mem_model[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem_model[mem_addr[7:0]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Entry: {is_call, ovl, size, expected base, expected size}.
    localparam logic [31:0] TBL [9] = '{
        {1'b1, 5'd2,  5'd8,  16'd14, 5'd8},
        {1'b1, 5'd0,  5'd0,  16'd22, 5'd1},
        {1'b1, 5'd5,  5'd20, 16'd22, 5'd16},
        {1'b1, 5'd16, 5'd4,  16'd22, 5'd4},
        {1'b0, 5'd0,  5'd0,  16'd22, 5'd16},
        {1'b0, 5'd0,  5'd0,  16'd22, 5'd1},
        {1'b0, 5'd0,  5'd0,  16'd14, 5'd8},
        {1'b0, 5'd0,  5'd0,  16'd0,  5'd16},
        {1'b0, 5'd0,  5'd0,  16'd0,  5'd16}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] idx, input logic [31:0] exp);
        rd_idx = idx; #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic do_call(input logic [4:0] ovl, input logic [4:0] sz);
        @(negedge clk); call_req = 1'b1; call_ovl = ovl; call_size = sz;
        @(negedge clk); call_req = 1'b0;
    endtask

    task automatic do_ret();
        @(negedge clk); ret_req = 1'b1;
        @(negedge clk); ret_req = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 1000) begin @(negedge clk); n++; end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; rd_idx = '0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        call_req = 1'b0; call_ovl = '0; call_size = '0; ret_req = 1'b0;
        stack_bound = 16'd100; ack_hold = 1'b0; mem_ack = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 base", frame_base, 0);
        chk("R1 size", frame_size, 16);
        chk("R1 sp", mem_sp, 0);
        chk("R1 busy", busy, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 stk_ovf", stk_ovf, 0);
        rst_n = 1'b1;

        // R2: fill the first frame and read it back
        for (int i = 0; i < 16; i++) wr_reg(4'(i), 32'hA000_0000 + i);
        rd_chk("R2 readback idx0", 4'd0, 32'hA000_0000);
        rd_chk("R2 readback idx15", 4'd15, 32'hA000_000F);

        // R3 R5 R8: table of calls and returns with clamping
        for (int t = 0; t < 9; t++) begin
            if (TBL[t][31]) do_call(TBL[t][30:26], TBL[t][25:21]);
            else            do_ret();
            wait_idle();
            chk($sformatf("R3/R5 table %0d base", t), frame_base, TBL[t][20:5]);
            chk($sformatf("R3/R5 table %0d size", t), frame_size, TBL[t][4:0]);
            chk($sformatf("R8 table %0d sp", t), mem_sp, 0);
        end

        // R2: overlap shares caller words
        do_call(5'd4, 5'd8);
        chk("R3 overlap base", frame_base, 12);
        for (int i = 0; i < 4; i++) rd_chk("R2 overlap read", 4'(i), 32'hA000_000C + i);
        wr_reg(4'd0, 32'h0000_0055);
        do_ret();
        rd_chk("R2 callee write seen by caller", 4'd12, 32'h0000_0055);
        wr_reg(4'd12, 32'hA000_000C);

        // R8: descriptor stack full
        for (int i = 0; i < 8; i++) do_call(5'd0, 5'd1);
        chk("R8 eight calls base", frame_base, 23);
        do_call(5'd0, 5'd1);
        chk("R8 call when full ignored", frame_base, 23);
        for (int i = 0; i < 8; i++) do_ret();
        chk("R8 unwound base", frame_base, 0);
        chk("R8 unwound size", frame_size, 16);

        // R4 R6: fourth full frame forces a spill, held off by the memory
        do_call(5'd0, 5'd16);
        do_call(5'd0, 5'd16);
        do_call(5'd0, 5'd16);
        chk("R4 no spill at 64 words", busy, 0);
        @(posedge clk); ack_hold = 1'b1;
        do_call(5'd0, 5'd16);
        chk("R4 base 64", frame_base, 64);
        chk("R6 busy", busy, 1);
        chk("R4 mem_req", mem_req, 1);
        chk("R4 mem_we", mem_we, 1);
        chk("R4 mem_addr", mem_addr, 0);
        chk("R4 mem_wdata", mem_wdata, 32'hA000_0000);
        wr_reg(4'd0, 32'hDEAD_0000);
        do_call(5'd0, 5'd4);
        do_ret();
        @(posedge clk); ack_hold = 1'b0;
        wait_idle();
        chk("R6 call while busy ignored", frame_base, 64);
        chk("R6 size unchanged", frame_size, 16);
        chk("R4 sp after spill", mem_sp, 16);
        for (int i = 0; i < 16; i++)
            chk("R4 spilled word", mem_model[i], 32'hA000_0000 + i);
        rd_chk("R6 write while busy ignored", 4'd0, 32'hA000_0000);

        // R7: bound comparison
        stack_bound = 16'd10; #1;
        chk("R7 ovf above bound", stk_ovf, 1);
        stack_bound = 16'd16; #1;
        chk("R7 no ovf at bound", stk_ovf, 0);
        stack_bound = 16'd100;

        wr_reg(4'd0, 32'h0000_BEEF);

        // R9: call and return in the same cycle
        @(negedge clk); call_req = 1'b1; ret_req = 1'b1; call_ovl = 5'd8; call_size = 5'd4;
        @(negedge clk); call_req = 1'b0; ret_req = 1'b0;
        chk("R9 call wins base", frame_base, 72);
        chk("R9 call wins size", frame_size, 4);
        do_ret();
        chk("R5 return base", frame_base, 64);
        rd_chk("R2 reused slot", 4'd0, 32'h0000_BEEF);

        // R5: unwind until the first frame needs a refill
        do_ret(); do_ret(); do_ret();
        chk("R5 base 16", frame_base, 16);
        chk("R5 no fill yet", busy, 0);
        @(posedge clk); ack_hold = 1'b1;
        do_ret();
        chk("R5 base 0", frame_base, 0);
        chk("R5 fill req", mem_req, 1);
        chk("R5 fill we", mem_we, 0);
        chk("R5 fill addr", mem_addr, 15);
        @(posedge clk); ack_hold = 1'b0;
        wait_idle();
        chk("R5 sp after fill", mem_sp, 0);
        for (int i = 0; i < 16; i++) rd_chk("R5 refilled word", 4'(i), 32'hA000_0000 + i);
        chk("R5 size restored", frame_size, 16);

        finish_run();
    end
endmodule